// File: doc/BRIEF.md
# Real-Time Clock Square-Wave and Interrupt Pin Controller

This block holds the one-byte control register of a real-time clock and drives the clock's two open-drain-style output pins from it. The register stops or runs the timebase. It picks one of four square-wave rates, routes the alarm interrupts to the pins, and enables each alarm's interrupt. A 15-bit divider advances on a 32.768 kHz clock-enable tick and supplies the square-wave rates. It holds its count while the timebase is stopped.

The first pin always reports the first alarm as an active-low interrupt. The second pin is shared. With the routing bit clear it carries the selected square wave. With the routing bit set it becomes the active-low interrupt of the second alarm. The alarm flags come from a comparator outside this block. Register writes and reads come from a serial-bus slave outside this block.

Top module: `rtc_sqw_ctl`

## Requirements
- R1: After reset the register reads 0x18: timebase running, rate code 11, routing bit clear, both alarm enables clear.
- R2: The register bits are: bit 7 timebase stop (1 = stopped), bits 4:3 rate code, bit 2 routing, bit 1 second-alarm enable, bit 0 first-alarm enable. A write stores these bits and the read port returns them. Bits 6 and 5 ignore writes and always read 0.
- R3: With routing clear and rate code 11, the shared pin is high for exactly the one clock cycle after each tick taken while running, and low otherwise.
- R4: With routing clear, rate code 01 puts bit 2 of the divider count on the shared pin (4.096 kHz), and rate code 10 puts bit 1 there (8.192 kHz). The divider count is the number of ticks taken while running since reset, modulo 2^15.
- R5: With routing clear and rate code 00, the shared pin carries bit 14 of the divider count (1 Hz). It rises on the 16384th running tick and falls when the count wraps to zero.
- R6: While bit 7 is 1, ticks do not advance the divider and produce no pulse on the 11 rate.
- R7: With routing set, the shared pin is low exactly when the second-alarm flag and its enable are both 1.
- R8: The first-alarm pin is low exactly when the first-alarm flag and its enable are both 1, whatever the routing bit holds.
- R9: With routing clear, the second-alarm flag has no effect on the shared pin.
- R10: Writing the register does not reset the divider; the count continues across rate changes and stop/run changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| rd_data | output | 8 | Register read value |
| tick_32k | input | 1 | One-cycle 32.768 kHz clock enable |
| alarm1_flag | input | 1 | First-alarm match flag |
| alarm2_flag | input | 1 | Second-alarm match flag |
| int1_n | output | 1 | Active-low first-alarm interrupt pin |
| sqw_int2_n | output | 1 | Shared pin: square wave or active-low second-alarm interrupt |

## Verification
The divider count cannot be read directly. A wrong count shows up only as a shifted square-wave phase on the shared pin. On the 8.192 kHz and 4.096 kHz rates that shift is visible within four to eight ticks. On the 1 Hz rate it becomes visible only at a bit-14 boundary. For this reason the bench runs the 1 Hz rate to both its rising and its wrapping edge. A register bit stored in the wrong position appears on the read port one cycle after the write. It also changes the pin routing or gating in that same cycle.

// File: rtl/rtc_ctl_pkg.sv
`timescale 1ns/1ps
// Package: shared control-register layout and rate codes for the RTC pin controller.
// Assumes bit positions are fixed because software decodes them.
package rtc_ctl_pkg;

    typedef struct packed {
        logic       osc_stop;   // bit 7: 1 stops the timebase
        logic [1:0] pad;        // bits 6:5: always zero
        logic [1:0] rate_sel;   // bits 4:3: square-wave rate code
        logic       route_int;  // bit 2: shared pin carries alarm 2 interrupt
        logic       en2;        // bit 1: alarm 2 interrupt enable
        logic       en1;        // bit 0: alarm 1 interrupt enable
    } ctl_t;

    typedef enum logic [1:0] {
        RATE_1HZ  = 2'b00,
        RATE_4K   = 2'b01,
        RATE_8K   = 2'b10,
        RATE_32K  = 2'b11
    } rate_e;

    localparam logic [7:0] CTL_WR_MASK = 8'h9F;
    localparam ctl_t CTL_RESET = '{osc_stop: 1'b0, pad: 2'b00, rate_sel: 2'b11,
                                   route_int: 1'b0, en2: 1'b0, en1: 1'b0};

endpackage

// File: rtl/rtc_ctl_reg.sv
`timescale 1ns/1ps
// Module: control register storage.
// Holds the control byte; masks the two reserved bits so they never store a one.
// Assumes wr_en is a single-cycle strobe from the bus slave.
module rtc_ctl_reg
    import rtc_ctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output ctl_t       ctl_q
);

    // Load the masked write value, or the power-up value on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= CTL_RESET;
        end else if (wr_en) begin
            ctl_q <= ctl_t'(wr_data & CTL_WR_MASK);
        end
    end

endmodule

// File: rtl/rtc_rate_div.sv
`timescale 1ns/1ps
// Module: timebase divider.
// Counts reference ticks while running and produces a one-cycle pulse per running tick.
// Assumes tick is a one-cycle enable at the reference rate; count wraps modulo 2^DIV_W.
module rtc_rate_div #(
    parameter int DIV_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    output logic [DIV_W-1:0] count_q,
    output logic             pulse_q
);

    // Advance the count on each tick taken while running; hold it when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (tick && run) begin
            count_q <= count_q + 1'b1;
        end
    end

    // Register a pulse that marks the cycle after each running tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= tick && run;
        end
    end

endmodule

// File: rtl/rtc_pin_mux.sv
`timescale 1ns/1ps
// Module: output pin selection.
// Picks the square-wave tap from the rate code and routes the alarm interrupts.
// Assumes all inputs come from registers or from stable flags, so the outputs are decoded from state only.
module rtc_pin_mux
    import rtc_ctl_pkg::*;
#(
    parameter int DIV_W    = 15,
    parameter int TAP_SLOW = DIV_W - 1,
    parameter int TAP_4K   = 2,
    parameter int TAP_8K   = 1
) (
    input  ctl_t             ctl,
    input  logic [DIV_W-1:0] count,
    input  logic             pulse,
    input  logic             alarm1_flag,
    input  logic             alarm2_flag,
    output logic             int1_n,
    output logic             sqw_int2_n
);

    logic sq_wave;

    // Select the square-wave source from the rate code.
    always_comb begin
        unique case (rate_e'(ctl.rate_sel))
            RATE_1HZ: sq_wave = count[TAP_SLOW];
            RATE_4K:  sq_wave = count[TAP_4K];
            RATE_8K:  sq_wave = count[TAP_8K];
            default:  sq_wave = pulse;
        endcase
    end

    // Drive the dedicated interrupt pin and the shared pin.
    always_comb begin
        int1_n     = !(alarm1_flag && ctl.en1);
        sqw_int2_n = ctl.route_int ? !(alarm2_flag && ctl.en2) : sq_wave;
    end

endmodule

// File: rtl/rtc_sqw_ctl.sv
`timescale 1ns/1ps
// Module: RTC control register with square-wave and interrupt pin outputs (top).
// Ties the register, the timebase divider and the pin selection together.
// Assumes a synchronous active-low reset and a one-cycle reference tick.
module rtc_sqw_ctl
    import rtc_ctl_pkg::*;
#(
    parameter int DIV_W = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic       tick_32k,
    input  logic       alarm1_flag,
    input  logic       alarm2_flag,
    output logic       int1_n,
    output logic       sqw_int2_n
);

    ctl_t             ctl_q;
    logic [DIV_W-1:0] div_count;
    logic             div_pulse;

    rtc_ctl_reg u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ctl_q   (ctl_q)
    );

    rtc_rate_div #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_32k),
        .run     (!ctl_q.osc_stop),
        .count_q (div_count),
        .pulse_q (div_pulse)
    );

    rtc_pin_mux #(.DIV_W(DIV_W)) u_mux (
        .ctl         (ctl_q),
        .count       (div_count),
        .pulse       (div_pulse),
        .alarm1_flag (alarm1_flag),
        .alarm2_flag (alarm2_flag),
        .int1_n      (int1_n),
        .sqw_int2_n  (sqw_int2_n)
    );

    assign rd_data = ctl_q;

endmodule

// File: rtl/rtc_sqw_ctl_chk.sv
`timescale 1ns/1ps
// Module: property checker for rtc_sqw_ctl, attached through bind.
// Observes ports plus the divider count; drives nothing.
module rtc_sqw_ctl_chk #(
    parameter int DIV_W = 15
) (
    input logic             clk,
    input logic             rst_n,
    input logic [7:0]       rd_data,
    input logic             tick_32k,
    input logic             alarm1_flag,
    input logic             alarm2_flag,
    input logic             int1_n,
    input logic             sqw_int2_n,
    input logic [DIV_W-1:0] count
);

    // R2: reserved bits never read as one.
    p_pad_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[6:5] == 2'b00);

    // R4: a running tick advances the divider by one.
    p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_data[7] && tick_32k) |=> count == $past(count) + 1'b1);

    // R6: a stopped timebase holds the divider.
    p_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[7] |=> $stable(count));

    // R7: routed shared pin follows alarm 2 and its enable.
    p_int2_route_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[2] |-> (sqw_int2_n == !(alarm2_flag && rd_data[1])));

    // R8: dedicated pin follows alarm 1 and its enable.
    p_int1_pin_r8: assert property (@(posedge clk) disable iff (!rst_n)
        int1_n == !(alarm1_flag && rd_data[0]));

endmodule

bind rtc_sqw_ctl rtc_sqw_ctl_chk #(.DIV_W(DIV_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_data     (rd_data),
    .tick_32k    (tick_32k),
    .alarm1_flag (alarm1_flag),
    .alarm2_flag (alarm2_flag),
    .int1_n      (int1_n),
    .sqw_int2_n  (sqw_int2_n),
    .count       (u_div.count_q)
);

// File: tb/rtc_sqw_ctl_test.sv
`timescale 1ns/1ps
// Bench: scoreboard. Driver tasks push expected pin/register values; a monitor pops and compares.
module rtc_sqw_ctl_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    typedef struct {
        logic       e_int1;
        logic       e_sqw;
        logic [7:0] e_rd;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       tick_32k = 1'b0;
    logic       alarm1_flag = 1'b0;
    logic       alarm2_flag = 1'b0;
    logic       int1_n;
    logic       sqw_int2_n;

    exp_t       sb_q[$];
    int         checks = 0;
    int         fails  = 0;
    bit         done   = 1'b0;

    // Reference model state, built from the requirements.
    logic [7:0]  m_ctl   = 8'h18;
    logic [14:0] m_count = '0;
    logic        m_pulse = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_sqw_ctl uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .rd_data     (rd_data),
        .tick_32k    (tick_32k),
        .alarm1_flag (alarm1_flag),
        .alarm2_flag (alarm2_flag),
        .int1_n      (int1_n),
        .sqw_int2_n  (sqw_int2_n)
    );

    // One clock edge with the current inputs; update the model.
    task automatic step();
        @(posedge clk);
        #1;
        if (!rst_n) begin
            m_ctl = 8'h18; m_count = '0; m_pulse = 1'b0;
        end else begin
            m_pulse = tick_32k && !m_ctl[7];
            if (tick_32k && !m_ctl[7]) m_count = m_count + 1'b1;
            if (wr_en) m_ctl = wr_data & 8'h9F;
        end
    endtask

    function automatic logic model_sqw();
        if (m_ctl[2]) return !(alarm2_flag && m_ctl[1]);
        case (m_ctl[4:3])
            2'b00:   return m_count[14];
            2'b01:   return m_count[2];
            2'b10:   return m_count[1];
            default: return m_pulse;
        endcase
    endfunction

    // Push the model's expectation and wait for the monitor to compare it.
    task automatic expect_model(input string tag);
        exp_t it;
        it.e_int1 = !(alarm1_flag && m_ctl[0]);
        it.e_sqw  = model_sqw();
        it.e_rd   = m_ctl;
        it.tag    = tag;
        sb_q.push_back(it);
        @(negedge clk);
        #1;
    endtask

    task automatic write_ctl(input logic [7:0] v);
        wr_en = 1'b1; wr_data = v;
        step();
        wr_en = 1'b0;
    endtask

    // Monitor: compare the oldest expectation at the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0) begin
                exp_t it;
                it = sb_q.pop_front();
                checks++;
                if (int1_n !== it.e_int1 || sqw_int2_n !== it.e_sqw || rd_data !== it.e_rd) begin
                    fails++;
                    $display("FAIL %s: int1_n=%b exp %b, sqw_int2_n=%b exp %b, rd_data=%h exp %h",
                             it.tag, int1_n, it.e_int1, sqw_int2_n, it.e_sqw, rd_data, it.e_rd);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: run exceeded %0d cycles, exp completion", WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // Driver: stimulus sequence.
    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        expect_model("R1 reset value");

        // R3: one-cycle pulse per running tick on the fastest rate.
        tick_32k = 1'b1; step(); expect_model("R3 pulse high");
        tick_32k = 1'b0; step(); expect_model("R3 pulse low");

        // R2: stored bits and reserved bits.
        write_ctl(8'hFF); expect_model("R2 write FF reads 9F");
        write_ctl(8'h60); expect_model("R2 reserved bits read 0");

        // R4: 4.096 kHz tap then 8.192 kHz tap.
        write_ctl(8'h08);
        tick_32k = 1'b1;
        for (int i = 0; i < 16; i++) begin step(); expect_model("R4 4k tap"); end
        tick_32k = 1'b0;
        write_ctl(8'h10); expect_model("R10 count kept across write");
        tick_32k = 1'b1;
        for (int i = 0; i < 8; i++) begin step(); expect_model("R4 8k tap"); end
        tick_32k = 1'b0;

        // R6: stopped timebase freezes divider and pulses.
        write_ctl(8'h90);
        tick_32k = 1'b1;
        for (int i = 0; i < 6; i++) begin step(); expect_model("R6 frozen 8k"); end
        tick_32k = 1'b0;
        write_ctl(8'h98);
        tick_32k = 1'b1; step(); expect_model("R6 no pulse when stopped");
        tick_32k = 1'b0;
        write_ctl(8'h10); expect_model("R10 resume keeps count");
        tick_32k = 1'b1; step(); expect_model("R10 count continues");
        tick_32k = 1'b0;

        // R5: 1 Hz tap, rising and wrapping edges.
        write_ctl(8'h00);
        tick_32k = 1'b1;
        while (m_count != 15'd16383) step();
        expect_model("R5 before rise");
        step(); expect_model("R5 rise at 16384");
        while (m_count != 15'd32767) step();
        expect_model("R5 before wrap");
        step(); expect_model("R5 fall at wrap");
        tick_32k = 1'b0;

        // R7, R8: routed interrupts.
        write_ctl(8'h07);
        expect_model("R7 R8 idle high");
        alarm1_flag = 1'b1; step(); expect_model("R8 alarm1 asserts");
        alarm2_flag = 1'b1; step(); expect_model("R7 alarm2 asserts");
        write_ctl(8'h04);
        expect_model("R7 R8 enables gate interrupts");
        // R9: square wave ignores alarm 2; R8 independent of routing.
        write_ctl(8'h01);
        expect_model("R9 R8 alarm2 ignored, alarm1 active");
        alarm2_flag = 1'b0; step(); expect_model("R9 alarm2 removed no change");
        alarm2_flag = 1'b1;
        tick_32k = 1'b1; step(); expect_model("R9 square wave with alarm2 set");
        tick_32k = 1'b0; alarm1_flag = 1'b0; alarm2_flag = 1'b0;
        step(); expect_model("R8 alarm1 released");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule